// File: doc/BRIEF.md
# Hybrid Recursive / Non-Recursive Sinc Decimator

This block is the first decimation stage behind a single-bit sigma-delta modulator. Each clock it takes one modulator bit, maps it to a bipolar value and passes it through a fifth-order sinc filter. The output rate is 1/128 of the input rate. The enclosing filter chain decimates by 512 in total. Later stages in that chain correct the roughly 1 dB passband droop and apply the final half-band filter, so this block leaves the sinc response as it is.

The sinc filter is split in two. A recursive section runs at the full input rate and covers the first factor of 16. It has five integrators, followed by five combs with unit differential delay that run on the 1/16 strobe. Three non-recursive stages then each decimate by 2. Each one applies the binomial kernel (1+z^-1)^5 in polyphase form: incoming samples go alternately into an even bank and an odd bank, and the weighted sum is formed only once per output sample. Register widths follow the bit-growth rule. The integrators wrap in modular arithmetic, which leaves the final result exact.

Top module: `cic_hybrid_decim`

## Requirements
- R1: The input bit is mapped to +1 when it is 1 and to -1 when it is 0, before any arithmetic is done.
- R2: `out_vld` is a pulse one clock wide. Once output has started, consecutive pulses are exactly 128 clocks apart (16 x 2^3).
- R3: The recursive section produces sample j as the sum over k of g[k]*x[16j+10-k]. Here x[t] is the bipolar input at the t-th rising edge after reset is released (t counted from 0), with x[t]=0 for t<0. The coefficients g[k] are those of ((1-z^-16)/(1-z^-1))^5.
- R4: Each non-recursive stage maps its input sequence u to y[m] = sum over k=0..5 of C(5,k)*u[2m+1-k], with u[i]=0 for i<0. Output m is issued when input 2m+1 arrives.
- R5: Output sample n (the n-th `out_vld` pulse after reset, counted from 0) equals R4 applied three times to the sequence of R3.
- R6: The DC gain is 2^35. A constant 1 stream settles to +2^35 and a constant 0 stream settles to -2^35. A period-16 stream with p ones per period settles to 2^31*(2p-16).
- R7: `out_data` is a 37-bit two's-complement value (2 + 5*7 bits). Its magnitude never exceeds 2^35.
- R8: Reset is synchronous and active high. It clears every integrator, comb delay, bank register and phase counter. While reset is held and on the clock after it, `out_vld` is 0 and `out_data` is 0. After release, the block behaves as if it had an all-zero history.
- R9: `out_data` holds its value on every clock on which `out_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one modulator bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Modulator bitstream (1 means +1, 0 means -1) |
| out_data | output | 37 | Decimated two's-complement sample |
| out_vld | output | 1 | One-clock strobe marking a new `out_data` |

## Verification
Four properties are checked on every cycle:
- the output strobe is one clock wide and comes exactly every 128 clocks once running;
- the output magnitude stays within 2^35;
- the output holds its value between strobes;
- reset forces a zero output on the following clock.

The bench scenarios cover what those properties cannot see. They check the bipolar mapping, the exact sample alignment and the binomial weights of each stage. They check the settled DC gain for constant and periodic streams. They also check that a reset in mid-stream restores the zero-history response. For this, the outputs are compared against a direct-sum model of the sinc cascade, run on constant, periodic and pseudo-random bitstreams.

// File: rtl/cic_hyb_pkg.sv
package cic_hyb_pkg;

   // binomial coefficient C(n,k), zero outside 0..n
   function automatic int binom(input int n, input int k);
      int r;
      r = 1;
      if (k < 0 || k > n) return 0;
      for (int i = 1; i <= k; i++) r = r * (n - k + i) / i;
      return r;
   endfunction

   // width after the recursive section: bipolar input (2 bits) plus growth
   function automatic int cic_width(input int order, input int rdec);
      return 2 + order * $clog2(rdec);
   endfunction

   // each decimate-by-2 binomial stage grows by 'order' bits
   function automatic int out_width(input int order, input int rdec, input int nst);
      return cic_width(order, rdec) + order * nst;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 1) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
   parameter int ORDER = 5,
   parameter int W     = 22
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                bit_in,
   output logic signed [W-1:0] acc_out
);
   localparam logic signed [W-1:0] STEP_P = W'(1);
   localparam logic signed [W-1:0] STEP_N = {W{1'b1}};

   logic signed [W-1:0] step;
   assign step = bit_in ? STEP_P : STEP_N;

   // registered integrators; wrap-around is harmless for the final result
   for (genvar i = 0; i < ORDER; i++) begin : g_int
      logic signed [W-1:0] acc;
      logic signed [W-1:0] feed;
      if (i == 0) begin : g_head
         assign feed = step;
      end else begin : g_link
         assign feed = g_int[i-1].acc;
      end
      always_ff @(posedge clk) begin
         if (rst) acc <= '0;
         else     acc <= acc + feed;
      end
   end

   assign acc_out = g_int[ORDER-1].acc;
endmodule

// File: rtl/cic_comb_dec.sv
module cic_comb_dec #(
   parameter int ORDER = 5,
   parameter int RDEC  = 16,
   parameter int W     = 22
) (
   input  logic                clk,
   input  logic                rst,
   input  logic signed [W-1:0] samp,
   output logic signed [W-1:0] cic_out,
   output logic                cic_vld
);
   localparam int CW = $clog2(RDEC);

   logic [CW-1:0] cnt;
   logic          take;
   assign take = (cnt == CW'(RDEC - 1));

   always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else     cnt <= cnt + 1'b1;
   end

   // unit-delay differentiators, updated only on the decimation strobe
   for (genvar k = 0; k < ORDER; k++) begin : g_cmb
      logic signed [W-1:0] din;
      logic signed [W-1:0] dly;
      logic signed [W-1:0] dif;
      if (k == 0) begin : g_head
         assign din = samp;
      end else begin : g_link
         assign din = g_cmb[k-1].dif;
      end
      assign dif = din - dly;
      always_ff @(posedge clk) begin
         if (rst)       dly <= '0;
         else if (take) dly <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cic_out <= '0;
         cic_vld <= 1'b0;
      end else begin
         cic_vld <= take;
         if (take) cic_out <= g_cmb[ORDER-1].dif;
      end
   end
endmodule

// File: rtl/nr_poly_dec2.sv
module nr_poly_dec2
   import cic_hyb_pkg::*;
#(
   parameter int ORDER = 5,
   parameter int WI    = 22
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic signed [WI-1:0]      din,
   input  logic                      din_vld,
   output logic signed [WI+ORDER-1:0] dout,
   output logic                      dout_vld
);
   localparam int WO = WI + ORDER;
   localparam int NE = (ORDER + 1) / 2;  // even-index samples, odd taps
   localparam int NO = ORDER / 2;        // stored odd-index samples, even taps >= 2

   logic                 ph;
   logic signed [WO-1:0] ebank [NE];
   logic signed [WO-1:0] obank [NO];
   logic signed [WO-1:0] dext;
   logic signed [WO-1:0] acc;
   logic signed [WO-1:0] cf;

   assign dext = WO'(din);

   // one weighted sum per output sample: polyphase evaluation at output rate
   always_comb begin
      acc = dext * WO'(binom(ORDER, 0));
      cf  = '0;
      for (int i = 0; i < NE; i++) begin
         cf  = WO'(binom(ORDER, 2 * i + 1));
         acc = acc + cf * ebank[i];
      end
      for (int i = 0; i < NO; i++) begin
         cf  = WO'(binom(ORDER, 2 * i + 2));
         acc = acc + cf * obank[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph       <= 1'b0;
         dout     <= '0;
         dout_vld <= 1'b0;
         for (int i = 0; i < NE; i++) ebank[i] <= '0;
         for (int i = 0; i < NO; i++) obank[i] <= '0;
      end else begin
         dout_vld <= 1'b0;
         if (din_vld) begin
            ph <= ~ph;
            if (!ph) begin
               ebank[0] <= dext;
               for (int i = 1; i < NE; i++) ebank[i] <= ebank[i-1];
            end else begin
               obank[0] <= dext;
               for (int i = 1; i < NO; i++) obank[i] <= obank[i-1];
               dout     <= acc;
               dout_vld <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/cic_hybrid_decim.sv
module cic_hybrid_decim
   import cic_hyb_pkg::*;
#(
   parameter int ORDER     = 5,
   parameter int REC_DECIM = 16,
   parameter int NR_STAGES = 3
) (
   input  logic                                                  clk,
   input  logic                                                  rst,
   input  logic                                                  bit_in,
   output logic [out_width(ORDER, REC_DECIM, NR_STAGES)-1:0]     out_data,
   output logic                                                  out_vld
);
   localparam int W_CIC = cic_width(ORDER, REC_DECIM);
   localparam int OUT_W = out_width(ORDER, REC_DECIM, NR_STAGES);

   if (ORDER < 2) begin : g_bad_order
      $error("cic_hybrid_decim: ORDER must be at least 2");
   end
   if (!is_pow2(REC_DECIM)) begin : g_bad_rdec
      $error("cic_hybrid_decim: REC_DECIM must be a power of two >= 2");
   end
   if (NR_STAGES < 1) begin : g_bad_nst
      $error("cic_hybrid_decim: NR_STAGES must be at least 1");
   end
   if (OUT_W > 64) begin : g_bad_width
      $error("cic_hybrid_decim: output wider than 64 bits");
   end

   logic signed [W_CIC-1:0] int_out;
   logic signed [W_CIC-1:0] cic_out;
   logic                    cic_vld;

   cic_integ_chain #(.ORDER(ORDER), .W(W_CIC)) i_integ (
      .clk    (clk),
      .rst    (rst),
      .bit_in (bit_in),
      .acc_out(int_out)
   );

   cic_comb_dec #(.ORDER(ORDER), .RDEC(REC_DECIM), .W(W_CIC)) i_comb (
      .clk    (clk),
      .rst    (rst),
      .samp   (int_out),
      .cic_out(cic_out),
      .cic_vld(cic_vld)
   );

   for (genvar s = 0; s < NR_STAGES; s++) begin : g_nr
      localparam int WI = W_CIC + s * ORDER;
      logic signed [WI-1:0]       si;
      logic                       sv;
      logic signed [WI+ORDER-1:0] so;
      logic                       ov;
      if (s == 0) begin : g_first
         assign si = cic_out;
         assign sv = cic_vld;
      end else begin : g_next
         assign si = g_nr[s-1].so;
         assign sv = g_nr[s-1].ov;
      end
      nr_poly_dec2 #(.ORDER(ORDER), .WI(WI)) i_stage (
         .clk     (clk),
         .rst     (rst),
         .din     (si),
         .din_vld (sv),
         .dout    (so),
         .dout_vld(ov)
      );
   end

   assign out_data = g_nr[NR_STAGES-1].so;
   assign out_vld  = g_nr[NR_STAGES-1].ov;
endmodule

// File: rtl/cic_hybrid_decim_chk.sv
module cic_hybrid_decim_chk #(
   parameter int OUT_W  = 37,
   parameter int PERIOD = 128
) (
   input logic             clk,
   input logic             rst,
   input logic             out_vld,
   input logic [OUT_W-1:0] out_data
);
   localparam longint LIM = longint'(1) << (OUT_W - 2);

   longint val;
   int     gap;
   logic   seen;

   assign val = longint'($signed(out_data));

   always_ff @(posedge clk) begin
      if (rst) begin
         gap  <= 0;
         seen <= 1'b0;
      end else if (out_vld) begin
         gap  <= 0;
         seen <= 1'b1;
      end else begin
         gap <= gap + 1;
      end
   end

   // R2: strobe lasts one clock
   a_r2_pulse_width: assert property (@(posedge clk) disable iff (rst)
      out_vld |=> !out_vld);

   // R2: strobes are exactly PERIOD clocks apart
   a_r2_spacing: assert property (@(posedge clk) disable iff (rst)
      (out_vld && seen) |-> (gap == PERIOD - 1));

   // R7: output magnitude bounded by the DC gain
   a_r7_range: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> (val <= LIM && val >= -LIM));

   // R8: reset clears the output on the following clock
   a_r8_reset_clear: assert property (@(posedge clk)
      rst |=> (!out_vld && out_data == '0));

   // R9: output holds between strobes
   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      !out_vld |-> $stable(out_data));
endmodule

bind cic_hybrid_decim cic_hybrid_decim_chk #(
   .OUT_W (OUT_W),
   .PERIOD(REC_DECIM << NR_STAGES)
) i_chk (
   .clk     (clk),
   .rst     (rst),
   .out_vld (out_vld),
   .out_data(out_data)
);

// File: tb/test_cic_hybrid_decim.sv
`timescale 1ns/1ps
module test_cic_hybrid_decim;
   localparam int OW   = 37;
   localparam int L    = 128 * 40;
   localparam int GLEN = 76;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          bit_in = 1'b0;
   logic [OW-1:0] out_data;
   logic          out_vld;

   int  errors = 0;
   int  checks = 0;
   bit  done   = 1'b0;

   bit     xs [L];
   longint gk [GLEN];
   longint got [64];
   int     gt  [64];
   int     ng;
   longint c5 [6] = '{1, 5, 10, 10, 5, 1};

   always #5 clk = ~clk;

   cic_hybrid_decim i_cic_hybrid_decim (
      .clk     (clk),
      .rst     (rst),
      .bit_in  (bit_in),
      .out_data(out_data),
      .out_vld (out_vld)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint xv(input int i);
      if (i < 0 || i >= L) return 0;
      return xs[i] ? 64'sd1 : -64'sd1;
   endfunction

   // coefficients of the 16-tap boxcar raised to the fifth power
   task automatic build_g();
      longint tmp [GLEN];
      int len;
      foreach (gk[i]) gk[i] = 0;
      gk[0] = 1;
      len = 1;
      for (int p = 0; p < 5; p++) begin
         for (int n = 0; n < GLEN; n++) begin
            longint s;
            s = 0;
            for (int d = 0; d < 16; d++)
               if (n - d >= 0 && n - d < len) s += gk[n-d];
            tmp[n] = s;
         end
         len = len + 15;
         foreach (gk[i]) gk[i] = tmp[i];
      end
   endtask

   function automatic void dec2(input longint src [], output longint dst []);
      dst = new[src.size() / 2];
      for (int m = 0; m < dst.size(); m++) begin
         longint s;
         s = 0;
         for (int k = 0; k < 6; k++)
            if (2 * m + 1 - k >= 0) s += c5[k] * src[2*m+1-k];
         dst[m] = s;
      end
   endfunction

   task automatic run_scn(input string tag);
      longint held;
      bit     prev_vld, hold_ok, width_ok;
      longint cs [], y1 [], y2 [], y3 [];
      rst = 1'b1;
      repeat (3) @(negedge clk);
      // R8: reset state visible at the ports
      chk(out_vld == 1'b0, {"R8 reset vld ", tag}, longint'(out_vld), 0);
      chk(out_data == '0, {"R8 reset data ", tag}, longint'($signed(out_data)), 0);
      ng = 0; held = 0; prev_vld = 0; hold_ok = 1; width_ok = 1;
      for (int t = 0; t < L + 2; t++) begin
         @(negedge clk);
         if (t > 0) begin
            if (out_vld) begin
               if (prev_vld) width_ok = 0;
               if (ng < 64) begin
                  got[ng] = longint'($signed(out_data));
                  gt[ng]  = t;
                  ng++;
               end
               held = longint'($signed(out_data));
            end else if (longint'($signed(out_data)) != held) begin
               hold_ok = 0;
            end
            prev_vld = out_vld;
         end
         rst    = 1'b0;
         bit_in = (t < L) ? xs[t] : 1'b0;
      end
      // reference: R3 recursive section then R4 three times (R5)
      cs = new[L / 16];
      for (int j = 0; j < L / 16; j++) begin
         longint s;
         s = 0;
         for (int k = 0; k < GLEN; k++) s += gk[k] * xv(16 * j + 10 - k);
         cs[j] = s;
      end
      dec2(cs, y1);
      dec2(y1, y2);
      dec2(y2, y3);
      chk(ng >= 36, {"R2 output count ", tag}, ng, 36);
      for (int n = 0; n < ng; n++)
         chk(got[n] == y3[n], {"R5 R3 R4 sample ", tag}, got[n], y3[n]);
      for (int n = 1; n < ng; n++)
         chk(gt[n] - gt[n-1] == 128, {"R2 spacing ", tag}, gt[n] - gt[n-1], 128);
      chk(width_ok, {"R2 one-clock strobe ", tag}, longint'(width_ok), 1);
      chk(hold_ok, {"R9 hold between strobes ", tag}, longint'(hold_ok), 1);
   endtask

   initial begin
      logic [15:0] lf;
      build_g();

      // R1 R6: constant ones
      foreach (xs[i]) xs[i] = 1'b1;
      run_scn("ones");
      chk(got[ng-1] == (64'sd1 <<< 35), "R1 R6 ones DC", got[ng-1], 64'sd1 <<< 35);

      // R1 R6: constant zeros (also a reset after a non-zero history, R8)
      foreach (xs[i]) xs[i] = 1'b0;
      run_scn("zeros");
      chk(got[ng-1] == -(64'sd1 <<< 35), "R1 R6 zeros DC", got[ng-1], -(64'sd1 <<< 35));

      // R6: period-16, five ones
      foreach (xs[i]) xs[i] = ((i % 16) inside {0, 3, 6, 9, 13});
      run_scn("p5");
      chk(got[ng-1] == -6 * (64'sd1 <<< 31), "R6 p=5 DC", got[ng-1], -6 * (64'sd1 <<< 31));

      // R6: period-16, twelve ones
      foreach (xs[i]) xs[i] = ((i % 16) < 12);
      run_scn("p12");
      chk(got[ng-1] == 8 * (64'sd1 <<< 31), "R6 p=12 DC", got[ng-1], 8 * (64'sd1 <<< 31));

      // R3 R4 R5: pseudo-random fixed pattern
      lf = 16'hACE1;
      for (int i = 0; i < L; i++) begin
         xs[i] = lf[0];
         lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
      end
      run_scn("lfsr");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule